// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a mode-0 serial slave that lets an external host read and write a bank of 64 eight-bit configuration registers. Every transaction opens with a header byte, sent most significant bit first, that packs a direction flag, a burst flag and a six-bit register address. While the header shifts in, and again while any write data byte shifts in, the slave returns a status byte on its serial output. The status byte combines a ready flag, a three-bit operating-state code and four status bits supplied by the surrounding logic. On a read, the byte after the header carries the addressed register's contents.

The serial clock, select and data input are brought into a faster system clock, at least four times the serial clock rate, through two-flop synchronisers, and their edges are detected there. The serial output is a data bit plus a drive enable, so the pad ring can build the three-state pin. The rest of the chip sees the register bank through a combinational read port.

Top module: `spiRegSlave`

## Requirements
- R1: Header byte layout: bit 7 is the direction (1 = read, 0 = write), bit 6 is the burst flag (1 = burst), and bits 5:0 are the register address.
- R2: From the start of a transaction, the status byte is presented on the serial output during the header, most significant bit first. Bit 7 is the active-low ready input, bits 6:4 are the state code input, and bits 3:0 are the four status inputs, all captured when the byte is loaded.
- R3: On a write, the status byte is presented again while the data byte shifts in. When its eighth bit is sampled, the data byte is stored in the addressed register and becomes visible on the read port.
- R4: On a read, the addressed register is shifted out most significant bit first in the byte after the header. The serial input is ignored during that byte, and no register changes.
- R5: The serial input is sampled on rising serial clock edges. The serial output changes only after falling serial clock edges, or when a transaction starts.
- R6: The output drive enable is low while select is high. In a non-burst transaction it also drops after the final bit of the data byte, while select is still low.
- R7: In burst mode the address advances by one after every data byte, wrapping from 63 to 0, until select goes high. This applies to both reads and writes.
- R8: If select goes high in the middle of a byte, the partial byte is discarded with no register write, and the next transaction starts with a header.
- R9: After reset every register reads 0 and the output drive enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclkIn | input | 1 | Serial clock from host, idles low |
| csnIn | input | 1 | Active-low select from host |
| siIn | input | 1 | Serial data from host |
| soOut | output | 1 | Serial data to host |
| soEn | output | 1 | Drive enable for the serial output pin |
| readyN | input | 1 | Active-low clock-stable flag for status bit 7 |
| stateCode | input | 3 | Operating-state code for status bits 6:4 |
| statusLow | input | 4 | Status bits 3:0 |
| cfgRdAddr | input | 6 | Register index for the on-chip read port |
| cfgRdData | output | 8 | Contents of the register at cfgRdAddr |

## Verification
A wrong bit counter or phase shows up first on the serial output. The status byte appears where read data was expected, or the reverse, within the very next byte of the same transaction. A stale or wrongly incremented address shows up at the on-chip read port as soon as the eighth bit of the affected write is sampled. In burst reads it appears as a wrong byte on the following serial byte, so burst runs that cross the 63-to-0 boundary expose it within one byte time. Select aborts are followed at once by a full transaction, so a leftover bit count corrupts the next header's decode and the status or data returned in it.

// File: rtl/spiRegPkg.sv
package spiRegPkg;
  localparam int ADDR_W    = 6;
  localparam int BYTE_W    = 8;
  localparam int REG_COUNT = 1 << ADDR_W;
  localparam int CNT_W     = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,
    PH_WR   = 2'd1,
    PH_RD   = 2'd2,
    PH_DONE = 2'd3
  } phaseT;

  typedef struct packed {
    logic               ldStatus;
    logic               ldRead;
    logic               shift;
    logic               wrEn;
    logic [ADDR_W-1:0]  addr;
    logic [BYTE_W-1:0]  wrData;
  } strobeT;
endpackage

// File: rtl/spiRegCtrl.sv
module spiRegCtrl
  import spiRegPkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclkIn,
  input  logic   csnIn,
  input  logic   siIn,
  output strobeT strb,
  output logic   soEn,
  output logic   csActive,
  output logic   csStart,
  output logic   sclkRise,
  output logic   sclkFall,
  output logic   hdrPhase
);
  localparam int LAST = SyncStages - 1;

  logic [SyncStages-1:0] sclkSh, csnSh, siSh;
  logic sclkQ, csActQ, soEnQ, burstQ;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shIn;
  logic [ADDR_W-1:0] addrQ;
  phaseT phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSh <= '0;
      csnSh  <= '1;
      siSh   <= '0;
      sclkQ  <= 1'b0;
      csActQ <= 1'b0;
    end else begin
      sclkSh <= {sclkSh[LAST-1:0], sclkIn};
      csnSh  <= {csnSh[LAST-1:0], csnIn};
      siSh   <= {siSh[LAST-1:0], siIn};
      sclkQ  <= sclkSh[LAST];
      csActQ <= ~csnSh[LAST];
    end
  end

  logic [BYTE_W-1:0] byteIn;
  logic byteDone, byteEdge;

  always_comb begin
    csActive = ~csnSh[LAST];
    csStart  = csActive & ~csActQ;
    sclkRise = csActive & sclkSh[LAST] & ~sclkQ;
    sclkFall = csActive & ~sclkSh[LAST] & sclkQ;
    byteIn   = {shIn[BYTE_W-2:0], siSh[LAST]};
    byteDone = sclkRise && (bitCnt == CNT_W'(BYTE_W - 1));
    byteEdge = sclkFall && (bitCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_HDR;
      bitCnt <= '0;
      shIn   <= '0;
      addrQ  <= '0;
      burstQ <= 1'b0;
      soEnQ  <= 1'b0;
    end else if (!csActive) begin
      phase  <= PH_HDR;
      bitCnt <= '0;
      soEnQ  <= 1'b0;
    end else begin
      soEnQ <= (phase != PH_DONE);
      if (sclkRise) begin
        shIn   <= byteIn;
        bitCnt <= bitCnt + CNT_W'(1);
      end
      if (byteDone) begin
        unique case (phase)
          PH_HDR: begin
            addrQ  <= byteIn[ADDR_W-1:0];
            burstQ <= byteIn[BYTE_W-2];
            phase  <= byteIn[BYTE_W-1] ? PH_RD : PH_WR;
          end
          PH_WR, PH_RD: begin
            if (burstQ) addrQ <= addrQ + ADDR_W'(1);
            else        phase <= PH_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strb.wrEn     = byteDone && (phase == PH_WR);
    strb.wrData   = byteIn;
    strb.addr     = addrQ;
    strb.ldStatus = csStart || (byteEdge && (phase == PH_WR));
    strb.ldRead   = byteEdge && (phase == PH_RD);
    strb.shift    = sclkFall && !strb.ldStatus && !strb.ldRead;
    soEn          = soEnQ;
    hdrPhase      = (phase == PH_HDR);
  end
endmodule

// File: rtl/spiRegData.sv
module spiRegData
  import spiRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic              readyN,
  input  logic [2:0]        stateCode,
  input  logic [3:0]        statusLow,
  input  logic [ADDR_W-1:0] cfgRdAddr,
  output logic [BYTE_W-1:0] cfgRdData,
  output logic              soOut
);
  logic [BYTE_W-1:0] bank [REG_COUNT];
  logic [BYTE_W-1:0] outSr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) bank[i] <= '0;
    end else if (strb.wrEn) begin
      bank[strb.addr] <= strb.wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             outSr <= '0;
    else if (strb.ldStatus) outSr <= {readyN, stateCode, statusLow};
    else if (strb.ldRead)   outSr <= bank[strb.addr];
    else if (strb.shift)    outSr <= {outSr[BYTE_W-2:0], 1'b0};
  end

  assign cfgRdData = bank[cfgRdAddr];
  assign soOut     = outSr[BYTE_W-1];
endmodule

// File: rtl/spiRegSlave.sv
module spiRegSlave
  import spiRegPkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclkIn,
  input  logic        csnIn,
  input  logic        siIn,
  output logic        soOut,
  output logic        soEn,
  input  logic        readyN,
  input  logic [2:0]  stateCode,
  input  logic [3:0]  statusLow,
  input  logic [5:0]  cfgRdAddr,
  output logic [7:0]  cfgRdData
);
  strobeT strb;
  logic csActive, csStart, sclkRise, sclkFall, hdrPhase, wrEnTap;

  spiRegCtrl #(.SyncStages(SyncStages)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csnIn(csnIn), .siIn(siIn),
    .strb(strb), .soEn(soEn), .csActive(csActive), .csStart(csStart),
    .sclkRise(sclkRise), .sclkFall(sclkFall), .hdrPhase(hdrPhase)
  );

  spiRegData data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .readyN(readyN),
    .stateCode(stateCode), .statusLow(statusLow),
    .cfgRdAddr(cfgRdAddr), .cfgRdData(cfgRdData), .soOut(soOut)
  );

  assign wrEnTap = strb.wrEn;
endmodule

// File: rtl/spiRegSlave_chk.sv
module spiRegSlave_chk (
  input logic clk,
  input logic rstN,
  input logic csActive,
  input logic csStart,
  input logic sclkRise,
  input logic sclkFall,
  input logic hdrPhase,
  input logic wrEnTap,
  input logic soOut,
  input logic soEn,
  input logic readyN
);
  // R6: driver released once select is seen high
  assert_hiz_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> !soEn);

  // R5: output only moves after a falling edge or transaction start
  assert_so_on_fall_R5: assert property (@(posedge clk) disable iff (!rstN)
    (csActive && $past(csActive) && !$past(sclkFall) && !$past(csStart))
      |-> $stable(soOut));

  // R2: ready flag leads the status byte
  assert_status_msb_R2: assert property (@(posedge clk) disable iff (!rstN)
    csStart |=> (soOut == $past(readyN)));

  // R3: register writes only on a sampling edge inside a transaction
  assert_write_on_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrEnTap |-> (sclkRise && csActive));

  // R8: deselect returns the sequencer to the header phase
  assert_abort_to_header_R8: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> hdrPhase);
endmodule

bind spiRegSlave spiRegSlave_chk chk_i (
  .clk(clk), .rstN(rstN), .csActive(csActive), .csStart(csStart),
  .sclkRise(sclkRise), .sclkFall(sclkFall), .hdrPhase(hdrPhase),
  .wrEnTap(wrEnTap), .soOut(soOut), .soEn(soEn), .readyN(readyN)
);

// File: tb/spiRegSlave_tb_top.sv
module spiRegSlave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 40;
  localparam int NVEC       = 6;
  // {addr[13:8], data[7:0]}
  localparam logic [13:0] VEC [NVEC] = '{14'h003C, 14'h01A5, 14'h11FF,
                                          14'h2101, 14'h3E80, 14'h3F5E};

  logic clk = 1'b0, rstN = 1'b0;
  logic sclkIn = 1'b0, csnIn = 1'b1, siIn = 1'b0;
  logic soOut, soEn;
  logic readyN = 1'b0;
  logic [2:0] stateCode = 3'b101;
  logic [3:0] statusLow = 4'hA;
  logic [5:0] cfgRdAddr = '0;
  logic [7:0] cfgRdData;

  int checks = 0, fails = 0, glitches = 0;
  logic [7:0] st;

  always #(CLK_PERIOD/2) clk = ~clk;

  spiRegSlave dut_i (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csnIn(csnIn), .siIn(siIn),
    .soOut(soOut), .soEn(soEn), .readyN(readyN), .stateCode(stateCode),
    .statusLow(statusLow), .cfgRdAddr(cfgRdAddr), .cfgRdData(cfgRdData)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic xferBits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      siIn = tx[i];
      #(HALF);
      rx[i] = soOut;
      sclkIn = 1'b1;
      #(HALF);
      if (soOut !== rx[i]) glitches++;
      sclkIn = 1'b0;
    end
  endtask

  task automatic startTx();
    csnIn = 1'b0;
    #(HALF);
  endtask

  task automatic endTx();
    #(HALF);
    csnIn = 1'b1;
    #(4*HALF);
  endtask

  task automatic rdPort(input logic [5:0] a, input logic [7:0] exp, input string req);
    cfgRdAddr = a;
    #1;
    chk(req, cfgRdData, exp);
  endtask

  initial begin
    #(100000*CLK_PERIOD);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    st = {readyN, stateCode, statusLow};
    #(3*CLK_PERIOD + 2);
    chk("R9 soEn low in reset", {7'd0, soEn}, 8'h00);
    rstN = 1'b1;
    #(4*CLK_PERIOD);
    rdPort(6'd0, 8'h00, "R9 reg0 reset");
    rdPort(6'd63, 8'h00, "R9 reg63 reset");
    chk("R9 soEn low after reset", {7'd0, soEn}, 8'h00);

    // table: single write then single read per vector (R1 direction decode)
    for (int v = 0; v < NVEC; v++) begin
      logic [5:0] a;
      logic [7:0] d;
      a = VEC[v][13:8];
      d = VEC[v][7:0];
      startTx();
      xferBits({2'b00, a}, 8, rx); chk("R2 status on write header", rx, st);
      xferBits(d, 8, rx);          chk("R3 status during write data", rx, st);
      endTx();
      rdPort(a, d, "R3 write stored");
      startTx();
      xferBits({2'b10, a}, 8, rx); chk("R2 status on read header", rx, st);
      xferBits(8'h00, 8, rx);      chk("R1 R4 read data", rx, d);
      endTx();
    end

    // R6: enable high in header, low after final bit, low after deselect
    startTx();
    chk("R6 soEn high during header", {7'd0, soEn}, 8'h01);
    xferBits(8'h0A, 8, rx);
    xferBits(8'h77, 8, rx);
    #(HALF);
    chk("R6 soEn low after final bit", {7'd0, soEn}, 8'h00);
    csnIn = 1'b1;
    #(4*HALF);
    chk("R6 soEn low while deselected", {7'd0, soEn}, 8'h00);

    // R4: SI ignored during read byte
    startTx();
    xferBits(8'h8A, 8, rx);
    xferBits(8'hFF, 8, rx); chk("R4 read with SI high", rx, 8'h77);
    endTx();
    rdPort(6'd10, 8'h77, "R4 reg10 unchanged");
    rdPort(6'd11, 8'h00, "R4 reg11 untouched");

    // R7: burst write across wrap 62,63,0
    startTx();
    xferBits({2'b01, 6'd62}, 8, rx); chk("R1 burst header status", rx, st);
    xferBits(8'h11, 8, rx); chk("R7 status burst byte0", rx, st);
    xferBits(8'h22, 8, rx); chk("R7 status burst byte1", rx, st);
    xferBits(8'h33, 8, rx); chk("R7 status burst byte2", rx, st);
    endTx();
    rdPort(6'd62, 8'h11, "R7 burst reg62");
    rdPort(6'd63, 8'h22, "R7 burst reg63");
    rdPort(6'd0,  8'h33, "R7 burst wrapped reg0");

    // R7: burst read across wrap 63,0,1
    startTx();
    xferBits({2'b11, 6'd63}, 8, rx);
    xferBits(8'h00, 8, rx); chk("R7 burst read 63", rx, 8'h22);
    xferBits(8'h00, 8, rx); chk("R7 burst read 0", rx, 8'h33);
    xferBits(8'h00, 8, rx); chk("R7 burst read 1", rx, 8'hA5);
    endTx();

    // R2: status inputs reflected, ready flag high
    readyN = 1'b1; stateCode = 3'b010; statusLow = 4'h3;
    #(4*CLK_PERIOD);
    startTx();
    xferBits({2'b10, 6'd1}, 8, rx); chk("R2 status with ready high", rx, 8'hA3);
    xferBits(8'h00, 8, rx);         chk("R4 read reg1", rx, 8'hA5);
    endTx();
    readyN = 1'b0; stateCode = 3'b101; statusLow = 4'hA;
    #(4*CLK_PERIOD);

    // R8: abort mid data byte, then mid header
    startTx();
    xferBits({2'b00, 6'd5}, 8, rx);
    xferBits(8'hF0, 4, rx);
    endTx();
    rdPort(6'd5, 8'h00, "R8 partial byte discarded");
    startTx();
    xferBits(8'hFF, 3, rx);
    endTx();
    startTx();
    xferBits({2'b00, 6'd6}, 8, rx); chk("R8 header after abort", rx, st);
    xferBits(8'h42, 8, rx);
    endTx();
    rdPort(6'd6, 8'h42, "R8 write after abort");
    rdPort(6'd5, 8'h00, "R8 reg5 still clear");

    checks++;
    if (glitches != 0) begin
      fails++;
      $display("FAIL R5 output moved while clock high actual=%0d expected=0", glitches);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule